// File: doc/BRIEF.md
# Rectangle Fill and Vertical Scroll Engine

This block is a small 2D drawing engine for a frame memory of 32-bit pixels. The host programs it through a narrow register write port: an operation code, a raster-operation code, a fill color, an origin, a destination row, a height and a width. Writing the width register launches the operation. The engine then walks every pixel of the rectangle and drives a single-ported pixel memory with one access per cycle. It either paints the rectangle with the fill color or moves a block of rows to another vertical position.

Each pixel written is the result of a raster operation. The operation combines a "new" value with the pixel already at the destination. The new value is the fill color for a fill, and the source pixel for a scroll. The old pixel is fetched only when the raster operation needs it. A scroll moves rows only and never changes the column. When the destination lies below the source, rows are walked from the bottom up, so overlapping blocks come out as if the source had been read in full first.

Top module: `rect_fill_scroll_engine`

## Requirements
- R1: After reset, busy is low, reg_ready is high and the pixel port makes no access.
- R2: With operation code 0x08, writing a non-zero width fills rows origin_y..origin_y+height-1 and columns origin_x..origin_x+width-1. Each pixel sits at word address row*2048 + column. No word outside the rectangle changes, and no address outside it is driven.
- R3: Raster code 0x83 writes the new value, 0x85 writes back the old pixel unchanged, and 0x86 writes new XOR old. Any other raster code behaves as 0x83.
- R4: A fill with raster code 0x83 issues no pixel reads; every access is a write.
- R5: With operation code 0x0B, each destination pixel (dest_y+r, origin_x+c) receives the source pixel (origin_y+r, origin_x+c), combined with the old destination pixel by the raster code. The column is always origin_x, and writes to the destination-X register (address 6) have no effect.
- R6: A scroll whose destination row is greater than its source row walks rows from bottom to top, so its first write lands on row dest_y+height-1. Any other scroll starts at row dest_y. In both cases the result equals a copy taken from an unmodified source.
- R7: A width or height of zero starts nothing: busy never rises and no pixel access occurs.
- R8: Busy rises in the cycle after the width write and stays high for exactly 1 + height*width*k cycles. k is 1 for a fill with code 0x83, 2 for a fill with 0x85/0x86 or a scroll with 0x83, and 3 for a scroll with 0x85/0x86. reg_ready is the inverse of busy, and a register write presented while reg_ready is low is dropped.
- R9: A width write while the operation register holds a code other than 0x08 or 0x0B starts nothing and leaves memory untouched.

Register addresses: 0 operation, 1 raster code, 2 fill color (blue 23:16, green 15:8, red 7:0, passed through unchanged), 3 origin Y, 4 origin X, 5 destination Y, 6 destination X, 7 height, 8 width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, taken when reg_ready is high |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | PIX_W | Register write data |
| reg_ready | output | 1 | High when register writes are accepted |
| busy | output | 1 | Operation in progress |
| mem_en | output | 1 | Pixel memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read (data returned next cycle) |
| mem_addr | output | COORD_W+ROW_SHIFT | Pixel word address, row*2^ROW_SHIFT + column |
| mem_wdata | output | PIX_W | Pixel write data |
| mem_rdata | input | PIX_W | Read data, valid the cycle after a read |

## Verification
The hardest case to reach is a downward scroll whose source and destination rows overlap under a raster code that needs the old pixel. A wrong walk order only shows when a source row is overwritten before it is read, and a wrong read sequence only shows when the old and source pixels differ. The stimulus sets up directed overlapping scrolls one and two rows apart in both directions, under all three raster codes, over a randomly filled memory. These are followed by constrained random fills and scrolls whose expected image is built from a snapshot copy. A register write injected while busy checks the hold-off.

// File: rtl/rbe_pkg.sv
package rbe_pkg;
  localparam logic [7:0] OP_FILL   = 8'h08;
  localparam logic [7:0] OP_SCROLL = 8'h0B;
  localparam logic [7:0] ROP_NEW   = 8'h83;
  localparam logic [7:0] ROP_KEEP  = 8'h85;
  localparam logic [7:0] ROP_XOR   = 8'h86;

  typedef enum logic [3:0] {
    RA_OP     = 4'd0,
    RA_ROP    = 4'd1,
    RA_FG     = 4'd2,
    RA_ORG_Y  = 4'd3,
    RA_ORG_X  = 4'd4,
    RA_DST_Y  = 4'd5,
    RA_DST_X  = 4'd6,
    RA_HEIGHT = 4'd7,
    RA_WIDTH  = 4'd8
  } reg_addr_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_RD_SRC, ST_RD_DST, ST_WRITE
  } seq_state_e;

  function automatic logic rop_needs_old(input logic [7:0] code);
    return (code == ROP_KEEP) || (code == ROP_XOR);
  endfunction
endpackage

// File: rtl/rbe_regs.sv
module rbe_regs
  import rbe_pkg::*;
#(
  parameter int PIX_W   = 32,
  parameter int COORD_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [3:0]         addr,
  input  logic [PIX_W-1:0]   wdata,
  input  logic               busy,
  output logic               ready,
  output logic [7:0]         op_o,
  output logic [7:0]         rop_o,
  output logic [PIX_W-1:0]   fg_o,
  output logic [COORD_W-1:0] org_y_o,
  output logic [COORD_W-1:0] org_x_o,
  output logic [COORD_W-1:0] dst_y_o,
  output logic [COORD_W-1:0] height_o,
  output logic [COORD_W-1:0] width_o,
  output logic               start_o
);
  logic               accept;
  logic [7:0]         op_q, rop_q;
  logic [PIX_W-1:0]   fg_q;
  logic [COORD_W-1:0] org_y_q, org_x_q, dst_y_q, height_q, width_q;
  logic               start_q;
  logic               op_known;
  logic [COORD_W-1:0] new_width;

  assign ready     = ~busy;
  assign accept    = wr & ~busy;
  assign op_known  = (op_q == OP_FILL) || (op_q == OP_SCROLL);
  assign new_width = wdata[COORD_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= '0;
      rop_q    <= ROP_NEW;
      fg_q     <= '0;
      org_y_q  <= '0;
      org_x_q  <= '0;
      dst_y_q  <= '0;
      height_q <= '0;
      width_q  <= '0;
      start_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (accept) begin
        case (reg_addr_e'(addr))
          RA_OP:     op_q     <= wdata[7:0];
          RA_ROP:    rop_q    <= wdata[7:0];
          RA_FG:     fg_q     <= wdata;
          RA_ORG_Y:  org_y_q  <= wdata[COORD_W-1:0];
          RA_ORG_X:  org_x_q  <= wdata[COORD_W-1:0];
          RA_DST_Y:  dst_y_q  <= wdata[COORD_W-1:0];
          RA_HEIGHT: height_q <= wdata[COORD_W-1:0];
          RA_WIDTH: begin
            width_q <= new_width;
            start_q <= (new_width != '0) && (height_q != '0) && op_known;
          end
          default: ;
        endcase
      end
    end
  end

  assign op_o     = op_q;
  assign rop_o    = rop_q;
  assign fg_o     = fg_q;
  assign org_y_o  = org_y_q;
  assign org_x_o  = org_x_q;
  assign dst_y_o  = dst_y_q;
  assign height_o = height_q;
  assign width_o  = width_q;
  assign start_o  = start_q;

  AST_START_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (height_q != '0) && (width_q != '0)); // R7
  AST_START_KNOWN_OP: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> op_known); // R9
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr) |=> $stable(fg_q) && $stable(op_q) && $stable(width_q)); // R8
endmodule

// File: rtl/rbe_walker.sv
module rbe_walker #(
  parameter int COORD_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               asc,
  input  logic [COORD_W-1:0] height,
  input  logic [COORD_W-1:0] width,
  input  logic               step,
  output logic [COORD_W-1:0] row,
  output logic [COORD_W-1:0] col,
  output logic               last
);
  localparam logic [COORD_W-1:0] ONE = COORD_W'(1);

  logic [COORD_W-1:0] r_q, c_q;
  logic               asc_q;
  logic               col_end, row_end;

  assign col_end = (c_q == width - ONE);
  assign row_end = (r_q == height - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q   <= '0;
      c_q   <= '0;
      asc_q <= 1'b1;
    end else if (load) begin
      r_q   <= '0;
      c_q   <= '0;
      asc_q <= asc;
    end else if (step) begin
      if (col_end) begin
        c_q <= '0;
        r_q <= r_q + ONE;
      end else begin
        c_q <= c_q + ONE;
      end
    end
  end

  assign row  = asc_q ? r_q : (height - ONE - r_q);
  assign col  = c_q;
  assign last = row_end && col_end;

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !col_end) |=> (col == $past(col) + ONE)); // R2
  AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && col_end && !last) |=> (col == '0)); // R2
  AST_ROW_UPWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !asc_q && col_end && !last) |=> (row == $past(row) - ONE)); // R6
endmodule

// File: rtl/rbe_rop.sv
module rbe_rop #(
  parameter int PIX_W = 32
) (
  input  logic [7:0]       code,
  input  logic [PIX_W-1:0] new_pix,
  input  logic [PIX_W-1:0] old_pix,
  output logic [PIX_W-1:0] result
);
  import rbe_pkg::*;

  always_comb begin
    case (code)
      ROP_KEEP: result = old_pix;
      ROP_XOR:  result = new_pix ^ old_pix;
      default:  result = new_pix;
    endcase
  end
endmodule

// File: rtl/rect_fill_scroll_engine.sv
module rect_fill_scroll_engine
  import rbe_pkg::*;
#(
  parameter  int PIX_W     = 32,
  parameter  int COORD_W   = 11,
  parameter  int ROW_SHIFT = 11,
  localparam int AW        = COORD_W + ROW_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [PIX_W-1:0] reg_wdata,
  output logic             reg_ready,
  output logic             busy,
  output logic             mem_en,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [PIX_W-1:0] mem_wdata,
  input  logic [PIX_W-1:0] mem_rdata
);
  function automatic logic [AW-1:0] pix_addr(input logic [COORD_W-1:0] y,
                                             input logic [COORD_W-1:0] x);
    return (AW'(y) << ROW_SHIFT) + AW'(x);
  endfunction

  logic [7:0]         op_q, rop_q;
  logic [PIX_W-1:0]   fg_q;
  logic [COORD_W-1:0] org_y, org_x, dst_y, height, width;
  logic               start;
  logic [COORD_W-1:0] row, col;
  logic               last;

  seq_state_e         state_q, state_d, first_st;
  logic [PIX_W-1:0]   src_q;
  logic               is_scroll, need_old, walk_up;
  logic               pix_write, op_done;
  logic [COORD_W-1:0] src_row_y, dst_row_y, pix_x;
  logic [PIX_W-1:0]   new_pix;

  rbe_regs #(.PIX_W(PIX_W), .COORD_W(COORD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .ready(reg_ready), .op_o(op_q), .rop_o(rop_q), .fg_o(fg_q),
    .org_y_o(org_y), .org_x_o(org_x), .dst_y_o(dst_y), .height_o(height),
    .width_o(width), .start_o(start)
  );

  assign is_scroll = (op_q == OP_SCROLL);
  assign need_old  = rop_needs_old(rop_q);
  assign walk_up   = is_scroll && (dst_y > org_y);
  assign pix_write = (state_q == ST_WRITE);
  assign op_done   = pix_write && last;

  rbe_walker #(.COORD_W(COORD_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(start), .asc(~walk_up),
    .height(height), .width(width), .step(pix_write),
    .row(row), .col(col), .last(last)
  );

  always_comb begin
    if (is_scroll)     first_st = ST_RD_SRC;
    else if (need_old) first_st = ST_RD_DST;
    else               first_st = ST_WRITE;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start) state_d = first_st;
      ST_RD_SRC: state_d = need_old ? ST_RD_DST : ST_WRITE;
      ST_RD_DST: state_d = ST_WRITE;
      ST_WRITE:  state_d = last ? ST_IDLE : first_st;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RD_DST) src_q <= mem_rdata;
    end
  end

  assign src_row_y = org_y + row;
  assign dst_row_y = (is_scroll ? dst_y : org_y) + row;
  assign pix_x     = org_x + col;

  assign mem_en   = (state_q != ST_IDLE);
  assign mem_we   = pix_write;
  assign mem_addr = (state_q == ST_RD_SRC) ? pix_addr(src_row_y, pix_x)
                                           : pix_addr(dst_row_y, pix_x);
  assign new_pix  = is_scroll ? (need_old ? src_q : mem_rdata) : fg_q;
  assign busy     = start || (state_q != ST_IDLE);

  rbe_rop #(.PIX_W(PIX_W)) u_rop (
    .code(rop_q), .new_pix(new_pix), .old_pix(mem_rdata), .result(mem_wdata)
  );

  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en); // R8
  AST_PLAIN_FILL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !is_scroll && rop_q == ROP_NEW) |-> mem_we); // R4
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !busy); // R8
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> mem_en); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !mem_en && !busy); // R1
endmodule

// File: tb/tb_rect_fill_scroll_engine.sv
`timescale 1ns/100ps
module tb_rect_fill_scroll_engine;
  localparam int PIX_W = 32;
  localparam int AW    = 22;
  localparam int ROWS  = 16;
  localparam int COLS  = 32;
  localparam int NW    = ROWS * COLS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [PIX_W-1:0] reg_wdata = '0;
  logic reg_ready, busy, mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [PIX_W-1:0] mem_wdata;
  logic [PIX_W-1:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  rect_fill_scroll_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ready(reg_ready), .busy(busy),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [31:0] bmem [0:NW-1];
  logic [31:0] expm [0:NW-1];
  int checks = 0;
  int errors = 0;
  int busy_cnt = 0, rd_cnt = 0, acc_cnt = 0;
  bit oob = 0;
  bit seen_wr = 0;
  logic [AW-1:0] first_wr = '0;

  function automatic int word_index(input logic [AW-1:0] a);
    int y, x;
    y = int'(a >> 11);
    x = int'(a & 22'h7ff);
    if (y >= ROWS || x >= COLS) return -1;
    return y * COLS + x;
  endfunction

  function automatic logic [31:0] bench_rop(input logic [7:0] code,
                                            input logic [31:0] nv, ov);
    if (code == 8'h85) return ov;
    if (code == 8'h86) return nv ^ ov;
    return nv;
  endfunction

  function automatic int cost(input logic [7:0] op, rop);
    bit rd_old;
    rd_old = (rop == 8'h85) || (rop == 8'h86);
    if (op == 8'h0B) return rd_old ? 3 : 2;
    return rd_old ? 2 : 1;
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      acc_cnt = acc_cnt + 1;
      if (word_index(mem_addr) < 0) oob = 1;
      else if (mem_we) begin
        bmem[word_index(mem_addr)] <= mem_wdata;
        if (!seen_wr) begin
          first_wr = mem_addr;
          seen_wr  = 1;
        end
      end else begin
        mem_rdata <= bmem[word_index(mem_addr)];
      end
    end
  end

  always @(negedge clk) begin
    if (busy) busy_cnt = busy_cnt + 1;
    if (mem_en && !mem_we) rd_cnt = rd_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_mem(input string req);
    int bad = 0;
    logic [31:0] a1 = '0, e1 = '0;
    for (int i = 0; i < NW; i++) begin
      if (bmem[i] !== expm[i]) begin
        if (bad == 0) begin a1 = bmem[i]; e1 = expm[i]; end
        bad++;
      end
    end
    check(bad == 0, req, "memory image", a1, e1);
    check(!oob, req, "address range", 32'(oob), 32'd0);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    while (!reg_ready) @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic run_op(input logic [7:0] op, input logic [7:0] rop,
                        input logic [31:0] fg, input int oy, input int ox,
                        input int dy, input int h, input int w,
                        input bit wr_fg, input bit poke, input string tag);
    bit started;
    int exp_busy;
    logic [31:0] snap [0:NW-1];
    wr_reg(4'd0, 32'(op));
    wr_reg(4'd1, 32'(rop));
    if (wr_fg) wr_reg(4'd2, fg);
    wr_reg(4'd3, 32'(oy));
    wr_reg(4'd4, 32'(ox));
    wr_reg(4'd5, 32'(dy));
    wr_reg(4'd6, 32'((ox + 5) % COLS));
    wr_reg(4'd7, 32'(h));
    busy_cnt = 0; rd_cnt = 0; acc_cnt = 0; seen_wr = 0; oob = 0;
    wr_reg(4'd8, 32'(w));
    if (poke) begin
      check(reg_ready == 1'b0, "R8", "ready while busy", 32'(reg_ready), 32'd0);
      reg_addr  = 4'd2;
      reg_wdata = ~fg;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    started = (op == 8'h08 || op == 8'h0B) && h != 0 && w != 0;
    exp_busy = started ? 1 + h * w * cost(op, rop) : 0;
    if (started && op == 8'h08) begin
      for (int r = 0; r < h; r++)
        for (int c = 0; c < w; c++)
          expm[(oy + r) * COLS + ox + c] = bench_rop(rop, fg, expm[(oy + r) * COLS + ox + c]);
    end else if (started) begin
      snap = expm;
      for (int r = 0; r < h; r++)
        for (int c = 0; c < w; c++)
          expm[(dy + r) * COLS + ox + c] =
            bench_rop(rop, snap[(oy + r) * COLS + ox + c], snap[(dy + r) * COLS + ox + c]);
    end
    compare_mem(tag);
    check(busy_cnt == exp_busy, "R8", "busy cycles", 32'(busy_cnt), 32'(exp_busy));
    if (!started)
      check(acc_cnt == 0, tag, "accesses when idle", 32'(acc_cnt), 32'd0);
    if (started && op == 8'h08 && rop == 8'h83)
      check(rd_cnt == 0, "R4", "reads in plain fill", 32'(rd_cnt), 32'd0);
    if (started && op == 8'h0B) begin
      int frow;
      frow = (dy > oy) ? dy + h - 1 : dy;
      check(first_wr == AW'(frow * 2048 + ox), "R6", "first written address",
            32'(first_wr), 32'(frow * 2048 + ox));
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < NW; i++) begin
      bmem[i] = $urandom;
      expm[i] = bmem[i];
    end
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1", "busy in reset", 32'(busy), 32'd0);
    check(reg_ready == 1'b1, "R1", "ready in reset", 32'(reg_ready), 32'd1);
    check(mem_en == 1'b0, "R1", "access in reset", 32'(mem_en), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && mem_en == 1'b0, "R1", "idle after reset", 32'(busy), 32'd0);

    // R2 plain fill, then R3 codes
    run_op(8'h08, 8'h83, 32'h00A1B2C3, 2, 3, 0, 3, 5, 1, 0, "R2");
    run_op(8'h08, 8'h86, 32'h0F0F0F0F, 1, 1, 0, 4, 6, 1, 0, "R3");
    run_op(8'h08, 8'h85, 32'h12345678, 5, 10, 0, 2, 7, 1, 0, "R3");
    run_op(8'h08, 8'h00, 32'h00FFEE11, 9, 20, 0, 2, 4, 1, 0, "R3");
    // R5 / R6 overlapping scrolls both directions, all codes
    run_op(8'h0B, 8'h83, 32'h0, 4, 2, 2, 5, 9, 1, 0, "R5");
    run_op(8'h0B, 8'h83, 32'h0, 2, 6, 3, 5, 9, 1, 0, "R6");
    run_op(8'h0B, 8'h86, 32'h0, 6, 0, 8, 4, 12, 1, 0, "R6");
    run_op(8'h0B, 8'h85, 32'h0, 8, 4, 7, 3, 6, 1, 0, "R5");
    run_op(8'h0B, 8'h86, 32'h0, 3, 12, 3, 3, 5, 1, 0, "R5");
    // R7 zero sizes, R9 unknown op
    run_op(8'h08, 8'h83, 32'hDEAD, 1, 1, 0, 0, 4, 1, 0, "R7");
    run_op(8'h08, 8'h83, 32'hBEEF, 1, 1, 0, 4, 0, 1, 0, "R7");
    run_op(8'h05, 8'h83, 32'hCAFE, 1, 1, 0, 3, 3, 1, 0, "R9");
    // R8 hold-off: poke fg while busy, then reuse latched fg
    run_op(8'h08, 8'h83, 32'h00445566, 10, 8, 0, 4, 8, 1, 1, "R8");
    run_op(8'h08, 8'h83, 32'h00445566, 0, 24, 0, 3, 8, 0, 0, "R8");

    for (int k = 0; k < 24; k++) begin
      int h, w, oy, dy, ox;
      logic [7:0] op, rop;
      h   = 1 + int'($urandom % 6);
      w   = 1 + int'($urandom % 8);
      oy  = int'($urandom % (ROWS + 1 - h));
      dy  = int'($urandom % (ROWS + 1 - h));
      ox  = int'($urandom % (COLS + 1 - w));
      op  = ($urandom % 2 == 0) ? 8'h08 : 8'h0B;
      case ($urandom % 3)
        0: rop = 8'h83;
        1: rop = 8'h85;
        default: rop = 8'h86;
      endcase
      run_op(op, rop, $urandom, oy, ox, dy, h, w, 1, 0, (op == 8'h08) ? "R2" : "R5");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule